// File: doc/BRIEF.md
# Fractional System Clock Divider

This block takes a fast core clock and produces a slower system clock at one of four ratios: 2, 2.5, 3 or 4 core cycles per system cycle. The half-integer ratio is built from both core clock edges, giving a period of five core half-periods. Alongside the divided clock, the block gives a one-core-cycle enable pulse for logic that stays in the core clock domain. The pulse marks every cycle in which the system clock rises.

The ratio is strapped by two pins while reset is held. After reset, software can write a new ratio at any time. The write is held as pending and is applied only where one output frame ends and the next begins. At that point the output is low and the new pattern starts high, so no short pulse can appear. The ratio in effect can be read back. The block applies no frequency limit; software is responsible for choosing a legal ratio.

Top module: `frac_sysclk_div`

## Requirements
- R1: Ratio code 2'b00 gives a system period of 2 core cycles, 2'b01 gives 2.5, 2'b10 gives 3 and 2'b11 gives 4. The high time is 2, 3, 3 and 4 core half-periods respectively. Each period starts high, and the first period starts in the first core cycle after reset is released.
- R2: While reset is high, the strap pins are sampled on every core rising edge, and the last sample becomes the ratio after reset. Pin changes after reset have no effect.
- R3: A software write presented while reset is high is ignored.
- R4: A write after reset becomes pending. It takes effect at the start of the next frame, where a frame is 5 core cycles for ratio 2.5 and one system period otherwise. A write sampled on the boundary edge itself takes effect at once. A later write before the boundary replaces an earlier one.
- R5: The ratio readback shows the ratio in effect. It changes only in a core cycle in which the system clock rises, and never shows a pending value.
- R6: Every high and low interval of the system clock lasts at least two core half-periods, including across a ratio change.
- R7: At ratio 2.5 each five-half-period pattern is three halves high then two halves low. It therefore uses both core edges, with one rising edge at a core rising edge and the next at a core falling edge.
- R8: The enable output is high for exactly those core cycles in which the system clock rises, either at the cycle start or at its middle. It is never high in two consecutive cycles.
- R9: While reset is high, the system clock and the enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset; strap sampling window |
| strap_sel_i | input | 2 | Ratio strap pins, read during reset |
| wr_en_i | input | 1 | Software write strobe for the ratio field |
| wr_ratio_i | input | 2 | Ratio code written by software |
| sclk_o | output | 1 | Divided system clock |
| sclk_en_o | output | 1 | Core-domain enable, high in cycles where sclk_o rises |
| ratio_o | output | 2 | Ratio code currently in effect |

## Verification
The case that matters most is a software write landing in the same core cycle as a frame boundary, where the pending ratio is loaded. The bench strobes the write onto the exact boundary edge and also one and two cycles before it. It then compares a per-half-period trace of the output against the old pattern up to the boundary and the new pattern after it. The same trace is scanned for any interval shorter than two half-periods. The readback is checked for its change in the cycle of the first rising edge of the new pattern.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int SEL_W = 2;
    localparam int PH_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        RATIO_2   = 2'b00,
        RATIO_2P5 = 2'b01,
        RATIO_3   = 2'b10,
        RATIO_4   = 2'b11
    } ratio_e;

    // Output levels for one core cycle: first half, second half, rise flag
    typedef struct packed {
        logic hi_a;
        logic hi_b;
        logic rise;
    } slot_t;

    // Core cycles in one repeating frame
    function automatic int frame_cycles(ratio_e r);
        case (r)
            RATIO_2:   return 2;
            RATIO_2P5: return 5;
            RATIO_3:   return 3;
            default:   return 4;
        endcase
    endfunction

    // Core half-periods in one system period
    function automatic int period_halves(ratio_e r);
        case (r)
            RATIO_2:   return 4;
            RATIO_2P5: return 5;
            RATIO_3:   return 6;
            default:   return 8;
        endcase
    endfunction

    // Core half-periods the system clock stays high
    function automatic int high_halves(ratio_e r);
        case (r)
            RATIO_2:   return 2;
            RATIO_2P5: return 3;
            RATIO_3:   return 3;
            default:   return 4;
        endcase
    endfunction

    function automatic logic [PH_W-1:0] last_phase(ratio_e r);
        return PH_W'(frame_cycles(r) - 1);
    endfunction

    function automatic logic half_level(ratio_e r, int h);
        return (h % period_halves(r)) < high_halves(r);
    endfunction

    // Levels of both halves of core cycle ph within the frame, and whether
    // the system clock rises anywhere inside that core cycle.
    function automatic slot_t slot_of(ratio_e r, logic [PH_W-1:0] ph);
        slot_t s;
        int    h;
        logic  prev;
        h      = 2 * int'(ph);
        prev   = half_level(r, h + 2 * frame_cycles(r) - 1);
        s.hi_a = half_level(r, h);
        s.hi_b = half_level(r, h + 1);
        s.rise = (s.hi_a & ~prev) | (~s.hi_a & s.hi_b);
        return s;
    endfunction

endpackage

// File: rtl/sdiv_ratio_ctl.sv
module sdiv_ratio_ctl
    import sdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] strap_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_ratio_i,
    input  logic             frame_end_i,
    output ratio_e           act_q_o,
    output ratio_e           act_d_o
);

    typedef struct packed {
        ratio_e act;
        ratio_e pend;
    } ctl_t;

    ctl_t st_d, st_q;
    ratio_e pend_new;

    always_comb begin
        st_d     = st_q;
        pend_new = wr_en_i ? ratio_e'(wr_ratio_i) : st_q.pend;
        if (rst_i) begin
            // strap window: pins win, writes are dropped
            st_d.act  = ratio_e'(strap_i);
            st_d.pend = ratio_e'(strap_i);
        end else begin
            st_d.pend = pend_new;
            if (frame_end_i) begin
                st_d.act = pend_new;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign act_q_o = st_q.act;
    assign act_d_o = st_d.act;

    // R5: ratio in effect only moves on a frame boundary
    p_hold_ratio_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_end_i |=> $stable(st_q.act))
        else $error("ratio changed off a frame boundary");

    // R4: a write after reset is captured as pending
    p_pend_load_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> (st_q.pend == ratio_e'($past(wr_ratio_i))))
        else $error("write not captured as pending");

endmodule

// File: rtl/sdiv_phase_gen.sv
module sdiv_phase_gen
    import sdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  ratio_e act_q_i,
    input  ratio_e act_d_i,
    output logic   frame_end_o,
    output logic   hi_a_o,
    output logic   hi_b_o,
    output logic   rise_o
);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        slot_t           slot;
    } gen_t;

    gen_t st_d, st_q;

    assign frame_end_o = (st_q.ph == last_phase(act_q_i));

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            // park on the last phase so the first edge after reset wraps
            st_d.ph   = last_phase(act_d_i);
            st_d.slot = '0;
        end else begin
            if (frame_end_o) begin
                st_d.ph = '0;
            end else begin
                st_d.ph = st_q.ph + PH_W'(1);
            end
            st_d.slot = slot_of(act_d_i, st_d.ph);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign hi_a_o = st_q.slot.hi_a;
    assign hi_b_o = st_q.slot.hi_b;
    assign rise_o = st_q.slot.rise;

    // R6: every frame ends fully low, so a new ratio may start there
    p_frame_end_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_end_o |-> (!hi_a_o && !hi_b_o))
        else $error("frame ended with output high");

    // R6: every frame starts with a full high core cycle and a rise
    p_frame_start_high_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_end_o |=> (hi_a_o && hi_b_o && rise_o))
        else $error("frame did not start high");

    // R8: enable pulses are isolated single cycles
    p_en_single_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o)
        else $error("enable held two cycles");

endmodule

// File: rtl/sdiv_clk_out.sv
module sdiv_clk_out (
    input  logic clk_i,
    input  logic hi_a_i,
    input  logic hi_b_i,
    output logic sclk_o
);

    // core-high half shows the first-half level, core-low half the second
    assign sclk_o = clk_i ? hi_a_i : hi_b_i;

endmodule

// File: rtl/frac_sysclk_div.sv
module frac_sysclk_div
    import sdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] strap_sel_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_ratio_i,
    output logic             sclk_o,
    output logic             sclk_en_o,
    output logic [SEL_W-1:0] ratio_o
);

    ratio_e act_q, act_d;
    logic   frame_end;
    logic   hi_a, hi_b;

    sdiv_ratio_ctl u_ctl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .strap_i     (strap_sel_i),
        .wr_en_i     (wr_en_i),
        .wr_ratio_i  (wr_ratio_i),
        .frame_end_i (frame_end),
        .act_q_o     (act_q),
        .act_d_o     (act_d)
    );

    sdiv_phase_gen u_gen (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .act_q_i     (act_q),
        .act_d_i     (act_d),
        .frame_end_o (frame_end),
        .hi_a_o      (hi_a),
        .hi_b_o      (hi_b),
        .rise_o      (sclk_en_o)
    );

    sdiv_clk_out u_out (
        .clk_i  (clk_i),
        .hi_a_i (hi_a),
        .hi_b_i (hi_b),
        .sclk_o (sclk_o)
    );

    assign ratio_o = act_q;

    // R5: readback moves only in a cycle carrying a system clock rise
    p_ratio_at_rise_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(ratio_o) && !$past(rst_i)) |-> sclk_en_o)
        else $error("readback changed without a rise");

endmodule

// File: tb/frac_sysclk_div_tb.sv
module frac_sysclk_div_tb;

    localparam int CLK_T = 10;
    localparam int QTR   = CLK_T / 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap_sel = 2'b00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_ratio = 2'b00;
    logic       sclk, sclk_en;
    logic [1:0] ratio;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic       ta  [64];
    logic       tbv [64];
    logic       te  [64];
    logic [1:0] tr  [64];

    int wc1 = -1, wc2 = -1;
    logic [1:0] wv1 = 2'b00, wv2 = 2'b00;

    always #(CLK_T/2) clk = ~clk;

    frac_sysclk_div u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .strap_sel_i (strap_sel),
        .wr_en_i     (wr_en),
        .wr_ratio_i  (wr_ratio),
        .sclk_o      (sclk),
        .sclk_en_o   (sclk_en),
        .ratio_o     (ratio)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Level of half-period h of a pattern started at h=0 (R1 / R7)
    function automatic logic exp_half(logic [1:0] code, int h);
        int p, hi;
        case (code)
            2'b00:   begin p = 4; hi = 2; end
            2'b01:   begin p = 5; hi = 3; end
            2'b10:   begin p = 6; hi = 3; end
            default: begin p = 8; hi = 4; end
        endcase
        return (h % p) < hi;
    endfunction

    task automatic do_reset(logic [1:0] early, logic [1:0] strap, bit wr_in_rst);
        @(negedge clk);
        rst = 1'b1; strap_sel = early;
        wr_en = wr_in_rst; wr_ratio = ~strap;
        repeat (3) @(negedge clk);
        strap_sel = strap;
        repeat (2) @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
    endtask

    // Cycle c begins at the c-th core rising edge after reset release
    task automatic capture(int n, logic [1:0] pin_late);
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #(QTR);
            ta[c] = sclk; te[c] = sclk_en; tr[c] = ratio;
            @(negedge clk); #(QTR);
            tbv[c] = sclk;
            wr_en = 1'b0;
            if (wc1 == c + 1) begin wr_en = 1'b1; wr_ratio = wv1; end
            if (wc2 == c + 1) begin wr_en = 1'b1; wr_ratio = wv2; end
            if (c == 3) strap_sel = pin_late;
        end
        wr_en = 1'b0; wc1 = -1; wc2 = -1;
    endtask

    task automatic check_pattern(logic [1:0] code, int start, int n, string tag);
        for (int c = start; c < start + n; c++) begin
            int   rel;
            logic ea, eb, pb, ee;
            rel = c - start;
            ea  = exp_half(code, 2*rel);
            eb  = exp_half(code, 2*rel + 1);
            pb  = (rel == 0) ? 1'b0 : exp_half(code, 2*rel - 1);
            ee  = (ea & ~pb) | (~ea & eb);
            check((ta[c] === ea) && (tbv[c] === eb) && (te[c] === ee), tag,
                  int'({ta[c], tbv[c], te[c]}), int'({ea, eb, ee}));
        end
    endtask

    task automatic check_ratio(int start, int n, logic [1:0] code, string tag);
        for (int c = start; c < start + n; c++)
            check(tr[c] === code, tag, int'(tr[c]), int'(code));
    endtask

    // R6: interior runs of equal level must be at least two halves long
    task automatic check_runts(int n);
        logic cur;
        int   run;
        bit   first;
        cur = ta[0]; run = 0; first = 1'b1;
        for (int h = 0; h < 2*n; h++) begin
            logic v;
            v = (h % 2 == 0) ? ta[h/2] : tbv[h/2];
            if (v === cur) run++;
            else begin
                if (!first) check(run >= 2, "R6 runt interval", run, 2);
                first = 1'b0; cur = v; run = 1;
            end
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk); rst = 1'b1; strap_sel = 2'b10; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #(QTR);
        check(sclk === 1'b0, "R9 sclk low in reset (high half)", int'(sclk), 0);
        check(sclk_en === 1'b0, "R9 enable low in reset", int'(sclk_en), 0);
        check(ratio === 2'b10, "R2 strap seen in reset", int'(ratio), 2);
        @(negedge clk); #(QTR);
        check(sclk === 1'b0, "R9 sclk low in reset (low half)", int'(sclk), 0);
    endtask

    task automatic t_ratio(logic [1:0] code);
        do_reset(~code, code, 1'b0);
        capture(20, code);
        check_pattern(code, 0, 20, (code == 2'b01) ? "R7 pattern at 2.5" : "R1 pattern");
        check_ratio(0, 20, code, "R2 last strap sample used");
        check_runts(20);
    endtask

    task automatic t_pins_and_reset_write();
        do_reset(2'b00, 2'b10, 1'b1);
        capture(12, 2'b11);
        check_ratio(0, 12, 2'b10, "R3 write in reset ignored / R2 late pins ignored");
        check_pattern(2'b10, 0, 12, "R3 pattern unchanged");
    endtask

    task automatic t_switch_on_boundary();
        do_reset(2'b00, 2'b00, 1'b0);
        wc1 = 2; wv1 = 2'b11;
        capture(14, 2'b00);
        check_ratio(0, 2, 2'b00, "R5 old ratio before boundary");
        check_ratio(2, 12, 2'b11, "R4 write on boundary immediate");
        check_pattern(2'b00, 0, 2, "R4 old pattern");
        check_pattern(2'b11, 2, 12, "R4 new pattern from boundary");
        check_runts(14);
    endtask

    task automatic t_switch_mid_frame();
        do_reset(2'b00, 2'b11, 1'b0);
        wc1 = 1; wv1 = 2'b00;
        capture(12, 2'b11);
        check_ratio(0, 4, 2'b11, "R5 pending not shown");
        check_ratio(4, 8, 2'b00, "R4 applied at next frame");
        check_pattern(2'b11, 0, 4, "R4 old pattern kept");
        check_pattern(2'b00, 4, 8, "R4 new pattern");
        check_runts(12);
    endtask

    task automatic t_override();
        do_reset(2'b00, 2'b10, 1'b0);
        wc1 = 1; wv1 = 2'b01;
        wc2 = 2; wv2 = 2'b11;
        capture(13, 2'b10);
        check_ratio(0, 3, 2'b10, "R5 ratio held until boundary");
        check_ratio(3, 10, 2'b11, "R4 later write wins");
        check_pattern(2'b11, 3, 10, "R4 pattern of last write");
        check_runts(13);
    endtask

    task automatic t_leave_half();
        do_reset(2'b00, 2'b01, 1'b0);
        wc1 = 2; wv1 = 2'b10;
        capture(17, 2'b01);
        check_ratio(0, 5, 2'b01, "R5 2.5 held for whole frame");
        check_ratio(5, 12, 2'b10, "R4 switch after 5-cycle frame");
        check_pattern(2'b01, 0, 5, "R7 frame before switch");
        check_pattern(2'b10, 5, 12, "R4 pattern after leaving 2.5");
        check_runts(17);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_ratio(2'b00);
        t_ratio(2'b01);
        t_ratio(2'b10);
        t_ratio(2'b11);
        t_pins_and_reset_write();
        t_switch_on_boundary();
        t_switch_mid_frame();
        t_override();
        t_leave_half();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule